// File: doc/BRIEF.md
# Banked Work RAM with Mirror Window

This block is the byte-wide working memory of a small processor system. The processor sees it through a plain bus port as two 4 KiB windows. The lower window always reaches the first 4 KiB of storage. The upper window reaches a bank chosen by a small bank register, which the processor reads and writes at a fixed I/O address. A second address range, just above the two windows, is a mirror: the block folds it back onto the windows by masking the offset before any other decoding.

A colour-mode input picks one of two personalities. In colour mode the full set of banks (32 KiB by default) can be reached, and the bank register is live. In monochrome mode the memory is a flat 8 KiB. The bank register then reads as all ones and ignores writes, but it keeps the value it held. Reads have one cycle of latency, and the read data holds its value until the next read. Storage is an inferred synchronous RAM with no defined power-on contents.

Top module: `wram_banked`

## Requirements
- R1: An address in 0xE000..0xFDFF is handled exactly as the address 0xC000 + ((address - 0xE000) & 0x1FFF), for reads and writes. Addresses from 0xFE00 upward are not mirrored.
- R2: After folding, 0xC000..0xCFFF reaches storage bytes 0..4095 in both modes, whatever the bank register holds.
- R3: In colour mode, 0xD000..0xDFFF reaches storage byte (address - 0xD000) + 4096 * bank.
- R4: In colour mode, a read of 0xFF70 returns the bank value in bits 2:0 with bits 7:3 zero. A write to 0xFF70 loads the bank from write-data bits 2:0.
- R5: A colour-mode write of 0 to the bank register selects bank 1, so the bank register never holds 0.
- R6: In monochrome mode, a read of 0xFF70 returns 0xFF and a write to 0xFF70 leaves the bank register unchanged, which is visible after a return to colour mode.
- R7: In monochrome mode, 0xD000..0xDFFF reaches storage bytes 4096..8191 (bank 1), whatever the bank register holds.
- R8: The read data appears in the cycle after the cycle in which the read strobe is sampled, for memory and for the bank register alike, and it holds until the next read.
- R9: Reset sets the bank register to 1 and the read data to 0xFF.
- R10: A read of any address outside the windows, the mirror and 0xFF70 returns 0xFF. A write to such an address changes no storage byte and does not change the bank register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, rising edge |
| rst | input | 1 | Synchronous active-high reset |
| color_mode | input | 1 | 1 = colour mode (banked), 0 = monochrome (flat 8 KiB) |
| cpu_addr | input | 16 | Byte address of the access |
| cpu_wdata | input | 8 | Write data |
| cpu_rd | input | 1 | Read strobe, one access per cycle |
| cpu_wr | input | 1 | Write strobe, one access per cycle |
| cpu_rdata | output | 8 | Registered read data |

## Verification
The assertions watch the bank register on every cycle. They check that it never holds zero, that it comes out of reset at 1, that colour-mode writes load it with zero turned into one, and that monochrome writes leave it alone. They also check that a read of the register address returns the mode-correct value one cycle later and that the read data holds while no read is issued. The mapping of storage cannot be shown from single cycles. Mirror folding, the fixed lower window, bank-dependent upper-window contents, the monochrome flat layout and writes to unmapped addresses leaving storage untouched are all shown only by the bench. Its scenarios write through one address and read back through another, across bank and mode changes.

// File: rtl/wram_pkg.sv
package wram_pkg;

    localparam logic [15:0] WIN_BASE     = 16'hC000;
    localparam logic [15:0] MIR_LO       = 16'hE000;
    localparam logic [15:0] MIR_HI       = 16'hFDFF;
    localparam logic [15:0] MIR_MASK     = 16'h1FFF;
    localparam logic [15:0] BANKSEL_ADDR = 16'hFF70;
    localparam logic [3:0]  FIXED_NIB    = 4'hC;
    localparam logic [3:0]  SWITCH_NIB   = 4'hD;
    localparam int          WIN_AW       = 12;
    localparam logic [7:0]  IDLE_BYTE    = 8'hFF;

    typedef enum logic [1:0] {
        TGT_NONE    = 2'd0,
        TGT_FIXED   = 2'd1,
        TGT_SWITCH  = 2'd2,
        TGT_BANKREG = 2'd3
    } tgt_e;

    typedef struct packed {
        tgt_e              tgt;
        logic [WIN_AW-1:0] off;
    } dec_t;

    function automatic logic [15:0] fold_mirror(input logic [15:0] a);
        if (a >= MIR_LO && a <= MIR_HI)
            return WIN_BASE + ((a - MIR_LO) & MIR_MASK);
        return a;
    endfunction

    function automatic dec_t decode(input logic [15:0] a);
        dec_t       d;
        logic [15:0] f;
        f     = fold_mirror(a);
        d.off = f[WIN_AW-1:0];
        if (f[15:12] == FIXED_NIB)
            d.tgt = TGT_FIXED;
        else if (f[15:12] == SWITCH_NIB)
            d.tgt = TGT_SWITCH;
        else if (f == BANKSEL_ADDR)
            d.tgt = TGT_BANKREG;
        else
            d.tgt = TGT_NONE;
        return d;
    endfunction

endpackage

// File: rtl/wram_addr_map.sv
module wram_addr_map
    import wram_pkg::*;
#(
    parameter int BANK_W = 3
) (
    input  logic [15:0]       addr,
    input  logic              color_mode,
    input  logic [BANK_W-1:0] cur_bank,
    output tgt_e              tgt,
    output logic [WIN_AW-1:0] off,
    output logic [BANK_W-1:0] bank_idx
);
    localparam logic [BANK_W-1:0] MONO_BANK = BANK_W'(1);

    dec_t dec;

    always_comb begin
        dec = decode(addr);
        tgt = dec.tgt;
        off = dec.off;
        if (dec.tgt == TGT_SWITCH)
            bank_idx = color_mode ? cur_bank : MONO_BANK;
        else
            bank_idx = '0;
    end
endmodule

// File: rtl/wram_bank_ctl.sv
module wram_bank_ctl #(
    parameter int BANK_W = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              color_mode,
    input  logic              sel_wr,
    input  logic [BANK_W-1:0] wr_val,
    output logic [BANK_W-1:0] cur_bank
);
    localparam logic [BANK_W-1:0] FIRST_SW = BANK_W'(1);

    always_ff @(posedge clk) begin
        if (rst)
            cur_bank <= FIRST_SW;
        else if (sel_wr && color_mode)
            cur_bank <= (wr_val == '0) ? FIRST_SW : wr_val;
    end
endmodule

// File: rtl/wram_bank_array.sv
module wram_bank_array #(
    parameter int AW = 12,
    parameter int DW = 8
) (
    input  logic          clk,
    input  logic          we,
    input  logic          re,
    input  logic [AW-1:0] addr,
    input  logic [DW-1:0] wdata,
    output logic [DW-1:0] rdata
);
    localparam int DEPTH = 1 << AW;

    logic [DW-1:0] mem [DEPTH];

    always_ff @(posedge clk) begin
        if (we)
            mem[addr] <= wdata;
        if (re)
            rdata <= mem[addr];
    end
endmodule

// File: rtl/wram_banked.sv
module wram_banked
    import wram_pkg::*;
#(
    parameter int NUM_BANKS = 8
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        color_mode,
    input  logic [15:0] cpu_addr,
    input  logic [7:0]  cpu_wdata,
    input  logic        cpu_rd,
    input  logic        cpu_wr,
    output logic [7:0]  cpu_rdata
);
    localparam int BANK_W = $clog2(NUM_BANKS);

    tgt_e              tgt;
    logic [WIN_AW-1:0] off;
    logic [BANK_W-1:0] bank_idx;
    logic [BANK_W-1:0] cur_bank;
    logic              ram_hit;
    logic [7:0]        bank_rd [NUM_BANKS];

    tgt_e              src_q;
    logic [BANK_W-1:0] src_bank_q;
    logic [7:0]        regval_q;

    wram_addr_map #(.BANK_W(BANK_W)) map_i (
        .addr       (cpu_addr),
        .color_mode (color_mode),
        .cur_bank   (cur_bank),
        .tgt        (tgt),
        .off        (off),
        .bank_idx   (bank_idx)
    );

    wram_bank_ctl #(.BANK_W(BANK_W)) ctl_i (
        .clk        (clk),
        .rst        (rst),
        .color_mode (color_mode),
        .sel_wr     (cpu_wr && (tgt == TGT_BANKREG)),
        .wr_val     (cpu_wdata[BANK_W-1:0]),
        .cur_bank   (cur_bank)
    );

    assign ram_hit = (tgt == TGT_FIXED) || (tgt == TGT_SWITCH);

    for (genvar g = 0; g < NUM_BANKS; g++) begin : g_bank
        localparam logic [BANK_W-1:0] IDX = BANK_W'(g);
        logic hit;
        assign hit = ram_hit && (bank_idx == IDX);
        wram_bank_array #(.AW(WIN_AW), .DW(8)) arr_i (
            .clk   (clk),
            .we    (cpu_wr && hit),
            .re    (cpu_rd && hit),
            .addr  (off),
            .wdata (cpu_wdata),
            .rdata (bank_rd[g])
        );
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            src_q      <= TGT_NONE;
            src_bank_q <= '0;
            regval_q   <= IDLE_BYTE;
        end else if (cpu_rd) begin
            src_q      <= tgt;
            src_bank_q <= bank_idx;
            regval_q   <= color_mode ? {{(8-BANK_W){1'b0}}, cur_bank} : IDLE_BYTE;
        end
    end

    always_comb begin
        case (src_q)
            TGT_FIXED, TGT_SWITCH: cpu_rdata = bank_rd[src_bank_q];
            TGT_BANKREG:           cpu_rdata = regval_q;
            default:               cpu_rdata = IDLE_BYTE;
        endcase
    end
endmodule

// File: rtl/wram_banked_chk.sv
module wram_banked_chk #(
    parameter int BANK_W = 3
) (
    input logic              clk,
    input logic              rst,
    input logic              color_mode,
    input logic [15:0]       cpu_addr,
    input logic [7:0]        cpu_wdata,
    input logic              cpu_rd,
    input logic              cpu_wr,
    input logic [7:0]        cpu_rdata,
    input logic [BANK_W-1:0] cur_bank
);
    localparam logic [15:0] SEL_A = 16'hFF70;

    // R5
    bank_nonzero_chk: assert property (@(posedge clk) disable iff (rst)
        cur_bank != '0);

    // R9
    reset_bank_chk: assert property (@(posedge clk)
        $past(rst) |-> (cur_bank == BANK_W'(1) && cpu_rdata == 8'hFF));

    // R4
    color_load_chk: assert property (@(posedge clk) disable iff (rst)
        (color_mode && cpu_wr && cpu_addr == SEL_A && cpu_wdata[BANK_W-1:0] != '0)
        |=> cur_bank == $past(cpu_wdata[BANK_W-1:0]));

    // R5
    zero_to_one_chk: assert property (@(posedge clk) disable iff (rst)
        (color_mode && cpu_wr && cpu_addr == SEL_A && cpu_wdata[BANK_W-1:0] == '0)
        |=> cur_bank == BANK_W'(1));

    // R6
    mono_hold_chk: assert property (@(posedge clk) disable iff (rst)
        (!color_mode && cpu_wr) |=> $stable(cur_bank));

    // R6
    mono_read_chk: assert property (@(posedge clk) disable iff (rst)
        (!color_mode && cpu_rd && cpu_addr == SEL_A) |=> cpu_rdata == 8'hFF);

    // R4
    color_read_chk: assert property (@(posedge clk) disable iff (rst)
        (color_mode && cpu_rd && cpu_addr == SEL_A)
        |=> cpu_rdata == {{(8-BANK_W){1'b0}}, $past(cur_bank)});

    // R8
    hold_rdata_chk: assert property (@(posedge clk) disable iff (rst)
        !cpu_rd |=> $stable(cpu_rdata));
endmodule

bind wram_banked wram_banked_chk #(.BANK_W(BANK_W)) chk_i (
    .clk        (clk),
    .rst        (rst),
    .color_mode (color_mode),
    .cpu_addr   (cpu_addr),
    .cpu_wdata  (cpu_wdata),
    .cpu_rd     (cpu_rd),
    .cpu_wr     (cpu_wr),
    .cpu_rdata  (cpu_rdata),
    .cur_bank   (cur_bank)
);

// File: tb/wram_banked_tb_top.sv
module wram_banked_tb_top;
    localparam int CLK_PERIOD = 10;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        color_mode = 1'b1;
    logic [15:0] cpu_addr = 16'h0000;
    logic [7:0]  cpu_wdata = 8'h00;
    logic        cpu_rd = 1'b0;
    logic        cpu_wr = 1'b0;
    logic [7:0]  cpu_rdata;

    int n_chk = 0;
    int n_bad = 0;

    logic [7:0] model [int];
    int         bank_m = 1;

    always #(CLK_PERIOD/2) clk = ~clk;

    wram_banked dut_i (
        .clk        (clk),
        .rst        (rst),
        .color_mode (color_mode),
        .cpu_addr   (cpu_addr),
        .cpu_wdata  (cpu_wdata),
        .cpu_rd     (cpu_rd),
        .cpu_wr     (cpu_wr),
        .cpu_rdata  (cpu_rdata)
    );

    function automatic logic [15:0] fold(input logic [15:0] a);
        if (a >= 16'hE000 && a <= 16'hFDFF)
            return 16'hC000 + ((a - 16'hE000) & 16'h1FFF);
        return a;
    endfunction

    function automatic int phys(input logic [15:0] a);
        logic [15:0] f;
        f = fold(a);
        if (f[15:12] == 4'hC) return int'(f[11:0]);
        if (f[15:12] == 4'hD) return (color_mode ? bank_m : 1) * 4096 + int'(f[11:0]);
        return -1;
    endfunction

    function automatic string tag_of(input logic [15:0] a);
        if (a >= 16'hE000 && a <= 16'hFDFF) return "R1";
        if (a[15:12] == 4'hC) return "R2";
        if (a[15:12] == 4'hD) return color_mode ? "R3" : "R7";
        if (a == 16'hFF70) return color_mode ? "R4" : "R6";
        return "R10";
    endfunction

    task automatic check(input string tag, input logic [15:0] a,
                         input logic [7:0] got, input logic [7:0] exp);
        n_chk++;
        if (got !== exp) begin
            n_bad++;
            $display("FAIL %s addr=%h got=%h exp=%h", tag, a, got, exp);
        end
    endtask

    task automatic do_write(input logic [15:0] a, input logic [7:0] d);
        int p;
        @(negedge clk);
        cpu_addr  = a;
        cpu_wdata = d;
        cpu_wr    = 1'b1;
        p = phys(a);
        if (p >= 0)
            model[p] = d;
        else if (a == 16'hFF70 && color_mode)
            bank_m = (d[2:0] == 3'd0) ? 1 : int'(d[2:0]);
        @(negedge clk);
        cpu_wr = 1'b0;
    endtask

    task automatic do_read(input logic [15:0] a, input string tag);
        int         p;
        logic [7:0] e;
        bit         known;
        p = phys(a);
        known = 1'b1;
        if (p >= 0) begin
            if (model.exists(p)) e = model[p];
            else known = 1'b0;
        end else if (a == 16'hFF70) begin
            e = color_mode ? 8'(bank_m) : 8'hFF;
        end else begin
            e = 8'hFF;
        end
        @(negedge clk);
        cpu_addr = a;
        cpu_rd   = 1'b1;
        @(negedge clk);
        cpu_rd = 1'b0;
        if (known) check(tag, a, cpu_rdata, e);
    endtask

    function automatic logic [15:0] pick_addr();
        int r;
        r = int'($urandom % 8);
        case (r)
            0, 1:    return 16'hC000 + 16'($urandom % 4096);
            2, 3:    return 16'hD000 + 16'($urandom % 4096);
            4:       return 16'hE000 + 16'($urandom % 16'h1E00);
            5:       return 16'hFF70;
            6:       return 16'hFE00 + 16'($urandom % 16'h170);
            default: return 16'($urandom % 16'hC000);
        endcase
    endfunction

    initial begin
        #(CLK_PERIOD * 150000);
        n_bad++;
        $display("FAIL watchdog expired");
        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end

    initial begin
        logic [15:0] a;
        logic [7:0]  hold;
        void'($urandom(32'd20231009));
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        // R9: reset values
        check("R9", 16'h0000, cpu_rdata, 8'hFF);
        do_read(16'hFF70, "R9");

        // R3 and R4: two banks hold distinct data at the same offset
        do_write(16'hFF70, 8'h02);
        do_write(16'hD123, 8'hAA);
        do_write(16'hFF70, 8'hF3);
        do_write(16'hD123, 8'hBB);
        do_read(16'hFF70, "R4");
        do_read(16'hD123, "R3");
        do_write(16'hFF70, 8'h02);
        do_read(16'hD123, "R3");

        // R5: writing 0 selects bank 1
        do_write(16'hFF70, 8'h08);
        do_read(16'hFF70, "R5");

        // R2: fixed window ignores the bank
        do_write(16'hFF70, 8'h05);
        do_write(16'hC055, 8'h5A);
        do_write(16'hFF70, 8'h07);
        do_read(16'hC055, "R2");

        // R1: mirror in both directions, including top of window
        do_write(16'hE456, 8'h3C);
        do_read(16'hC456, "R1");
        do_write(16'hC789, 8'h6E);
        do_read(16'hE789, "R1");
        do_write(16'hFDFF, 8'h91);
        do_read(16'hDDFF, "R1");

        // R6: monochrome hides and protects the bank register
        color_mode = 1'b0;
        do_read(16'hFF70, "R6");
        do_write(16'hFF70, 8'h03);
        // R7: flat layout uses bank 1 for the upper window
        do_write(16'hD010, 8'h77);
        color_mode = 1'b1;
        do_read(16'hFF70, "R6");
        do_write(16'hFF70, 8'h01);
        do_read(16'hD010, "R7");
        do_write(16'hFF70, 8'h04);
        color_mode = 1'b0;
        do_read(16'hD010, "R7");

        // R10: unmapped reads, writes leave storage alone
        do_write(16'hFE10, 8'h12);
        do_write(16'h8000, 8'h34);
        do_read(16'hFE00, "R10");
        do_read(16'hFF71, "R10");
        do_read(16'hD010, "R10");

        // R8: latency and hold
        do_read(16'hC055, "R8");
        hold = cpu_rdata;
        repeat (4) @(negedge clk);
        check("R8", 16'hC055, cpu_rdata, hold);
        @(negedge clk);
        cpu_addr = 16'hC456;
        cpu_rd   = 1'b1;
        @(posedge clk);
        #1;
        check("R8", 16'hC456, cpu_rdata, 8'h3C);
        @(negedge clk);
        cpu_rd = 1'b0;

        // random mix
        for (int i = 0; i < 4000; i++) begin
            if ($urandom % 50 == 0) color_mode = ~color_mode;
            a = pick_addr();
            if ($urandom % 2 == 0)
                do_write(a, 8'($urandom));
            else
                do_read(a, tag_of(a));
        end

        $display("  *** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
        $finish;
    end
endmodule